// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and presents one active-low interrupt request to a processor. Every source owns a mode register (trigger type plus a 3-bit priority) and a vector register. Software turns sources on and off and discards latched events through write-one bitmap commands. Among the sources that are pending and enabled, the controller picks the one with the highest priority. It pulls `irq_n` low only when that source outranks the interrupt currently in service.

The processor acknowledges an interrupt by reading the vector location. The read returns the winner's vector and records the winner on an internal nesting stack, so a higher-priority source can interrupt the handler while lower or equal ones wait. If nothing is eligible, the read returns a programmable spurious vector. A write to the end-of-interrupt location leaves the innermost level. The status location names the source in service.

Top module: `prio_intc`

## Requirements
- R1: After reset all sources are disabled, no edge event is latched, the nesting stack is empty, the spurious vector is 0, `irq_n` is 1, and the status and enable-mask reads return 0.
- R2: Writing the enable-set command (word 0x44) enables every source whose data bit is 1. Writing the enable-clear command (0x45) disables every such source. Bits that are 0 leave their source unchanged. Word 0x47 reads the enable mask, with bit n for source n.
- R3: Word 0x00+n is source n's mode register: type in bits [1:0], priority in bits [6:4], all other bits read 0. The type codes are 00 high level, 01 rising edge, 10 low level and 11 falling edge. Word 0x20+n is source n's 32-bit vector. Both read back what was written.
- R4: Low-level and falling-edge types take effect only for source 0 and for sources whose `src_ext` bit is 1. On any other source they behave as high level and rising edge.
- R5: An edge-type source latches a pending event on its selected edge of `src_in`, and the event is visible one cycle after the edge. The event is cleared by a 1 in the pending-clear command (0x46) or by a vector read that acknowledges that source. A level-type source is pending while its registered input is at its active level. Word 0x48 reads the pending bits of all sources, whether enabled or not.
- R6: `irq_n` is 0 exactly when some enabled, pending source has a priority strictly above the priority on top of the stack, or when such a source exists and the stack is empty.
- R7: Higher priority values win (7 highest, 0 lowest). Among equal priorities, the lower source number wins.
- R8: A read of word 0x40 while `irq_n` is 0 returns the winner's vector and pushes the winner onto the stack. Otherwise it returns the spurious vector (read/write at 0x43) and pushes nothing.
- R9: Word 0x41 reads the number of the source on top of the stack. It reads 0 when the stack is empty or when the latest vector read was spurious.
- R10: A write of any value to word 0x42 pops one stack level and clears the spurious indication. On an empty stack it has no effect, and eight such writes always return the controller to idle.
- R11: The stack holds at most eight levels and never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (vector reads have side effects) |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, else 0 |
| src_in | input | 32 | Raw interrupt source inputs |
| src_ext | input | 32 | Configuration mask of sources that may use inverted polarity |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle that a low `irq_n` always has an enabled pending source behind it and that nothing is requested while all sources are disabled. They also check that each acknowledging read grows the stack by one, that a spurious read leaves it alone, that end-of-interrupt writes shrink it by one or leave an empty stack empty, and that the stack never exceeds eight levels. Which vector wins on equal priority, the polarity override for non-external sources, when edge events are latched and cleared, and the status value after a spurious read show up only in the bench scenarios. There, a behavioural model predicts every read and the request line.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    // Address regions, selected by the bits above the source index
    localparam int RGN_MODE = 0;
    localparam int RGN_VEC  = 1;
    localparam int RGN_CTL  = 2;

    // Control region word offsets
    localparam int REG_VEC   = 0;
    localparam int REG_STAT  = 1;
    localparam int REG_EOI   = 2;
    localparam int REG_SPU   = 3;
    localparam int REG_ENSET = 4;
    localparam int REG_ENCLR = 5;
    localparam int REG_PCLR  = 6;
    localparam int REG_ENRD  = 7;
    localparam int REG_PEND  = 8;

    // Mode register layout: type in [1:0], priority starting here
    localparam int MODE_PRIO_LSB = 4;
endpackage

// File: rtl/prio_intc_srcdet.sv
module prio_intc_srcdet #(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0]      src_now,
    input  logic [N_SRC-1:0]      src_last,
    input  logic [N_SRC-1:0]      ext_ok,
    input  logic [N_SRC-1:0]      edge_pend,
    input  logic [N_SRC-1:0][1:0] trig,
    output logic [N_SRC-1:0]      edge_hit,
    output logic [N_SRC-1:0]      pend_eff
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic inv;
        logic is_edge;
        logic lvl_now;
        logic lvl_last;
        // inverted polarity only where permitted; otherwise falls back
        assign inv      = trig[i][1] & (ext_ok[i] | 1'(i == 0));
        assign is_edge  = trig[i][0];
        assign lvl_now  = src_now[i] ^ inv;
        assign lvl_last = src_last[i] ^ inv;
        assign edge_hit[i] = is_edge & lvl_now & ~lvl_last;
        assign pend_eff[i] = is_edge ? edge_pend[i] : lvl_last;
    end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             req,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output logic                         valid,
    output logic [ID_W-1:0]              win_id,
    output logic [PRIO_W-1:0]            win_prio
);
    // Scan from the top index down; >= lets a lower index take a tie.
    always_comb begin
        valid    = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!valid || prio[i] >= win_prio)) begin
                valid    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/prio_intc_nest.sv
module prio_intc_nest #(
    parameter int DEPTH  = 8,
    parameter int ID_W   = 5,
    parameter int PRIO_W = 3,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic              empty,
    output logic [ID_W-1:0]   top_id,
    output logic [PRIO_W-1:0] top_prio,
    output logic [CNT_W-1:0]  level
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0]   id;
        logic [DEPTH-1:0][PRIO_W-1:0] pr;
        logic [CNT_W-1:0]             cnt;
    } nest_t;

    nest_t s_d, s_q;
    logic [CNT_W-1:0] top_idx;
    logic [IDX_W-1:0] top_sel;

    assign top_idx  = s_q.cnt - 1'b1;
    assign top_sel  = top_idx[IDX_W-1:0];
    assign empty    = (s_q.cnt == '0);
    assign top_id   = empty ? '0 : s_q.id[top_sel];
    assign top_prio = s_q.pr[top_sel];
    assign level    = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (pop && !empty) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (push && s_q.cnt != CNT_W'(DEPTH)) begin
            s_d.id[s_q.cnt[IDX_W-1:0]] = push_id;
            s_d.pr[s_q.cnt[IDX_W-1:0]] = push_prio;
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_in,
    input  logic [N_SRC-1:0]  src_ext,
    output logic              irq_n
);
    localparam int ID_W  = $clog2(N_SRC);
    localparam int RGN_W = ADDR_W - ID_W;
    localparam int DEPTH = 1 << PRIO_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0]             epend;
        logic [N_SRC-1:0]             src;
        logic [N_SRC-1:0][1:0]        trig;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
        logic [N_SRC-1:0][VEC_W-1:0]  vec;
        logic [VEC_W-1:0]             spu;
        logic                         spur;
    } ctl_t;

    ctl_t c_d, c_q;

    // address decode
    logic [RGN_W-1:0] rgn;
    logic [ID_W-1:0]  off;
    logic in_ctl, wr_mode, wr_vec, rd_vec;
    logic wr_eoi, wr_spu, wr_enset, wr_enclr, wr_pclr;

    assign rgn      = bus_addr[ADDR_W-1:ID_W];
    assign off      = bus_addr[ID_W-1:0];
    assign in_ctl   = (rgn == RGN_W'(RGN_CTL));
    assign wr_mode  = bus_wr && (rgn == RGN_W'(RGN_MODE));
    assign wr_vec   = bus_wr && (rgn == RGN_W'(RGN_VEC));
    assign rd_vec   = bus_rd && in_ctl && (off == ID_W'(REG_VEC));
    assign wr_eoi   = bus_wr && in_ctl && (off == ID_W'(REG_EOI));
    assign wr_spu   = bus_wr && in_ctl && (off == ID_W'(REG_SPU));
    assign wr_enset = bus_wr && in_ctl && (off == ID_W'(REG_ENSET));
    assign wr_enclr = bus_wr && in_ctl && (off == ID_W'(REG_ENCLR));
    assign wr_pclr  = bus_wr && in_ctl && (off == ID_W'(REG_PCLR));

    // source detection
    logic [N_SRC-1:0] edge_hit, pend_eff, en_q, cand;

    prio_intc_srcdet #(.N_SRC(N_SRC)) u_det (
        .src_now   (src_in),
        .src_last  (c_q.src),
        .ext_ok    (src_ext),
        .edge_pend (c_q.epend),
        .trig      (c_q.trig),
        .edge_hit  (edge_hit),
        .pend_eff  (pend_eff)
    );

    assign en_q = c_q.en;
    assign cand = en_q & pend_eff;

    // arbitration
    logic              arb_valid;
    logic [ID_W-1:0]   arb_id;
    logic [PRIO_W-1:0] arb_prio;

    prio_intc_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .req      (cand),
        .prio     (c_q.prio),
        .valid    (arb_valid),
        .win_id   (arb_id),
        .win_prio (arb_prio)
    );

    // nesting stack
    logic              nest_empty;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio;
    logic [CNT_W-1:0]  nest_level;
    logic              irq_act, take;

    assign irq_act = arb_valid && (nest_empty || arb_prio > top_prio);
    assign take    = rd_vec && irq_act;
    assign irq_n   = ~irq_act;

    prio_intc_nest #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_nest (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_id   (arb_id),
        .push_prio (arb_prio),
        .pop       (wr_eoi),
        .empty     (nest_empty),
        .top_id    (top_id),
        .top_prio  (top_prio),
        .level     (nest_level)
    );

    // next state
    logic [N_SRC-1:0] clr_mask, ack_mask;

    always_comb begin
        c_d      = c_q;
        c_d.src  = src_in;
        clr_mask = wr_pclr ? bus_wdata[N_SRC-1:0] : '0;
        ack_mask = '0;
        if (take) ack_mask[arb_id] = 1'b1;
        // a fresh edge outranks a clear in the same cycle
        c_d.epend = (c_q.epend & ~clr_mask & ~ack_mask) | edge_hit;
        if (wr_enset) c_d.en = c_q.en | bus_wdata[N_SRC-1:0];
        if (wr_enclr) c_d.en = c_q.en & ~bus_wdata[N_SRC-1:0];
        if (wr_mode) begin
            c_d.trig[off] = bus_wdata[1:0];
            c_d.prio[off] = bus_wdata[MODE_PRIO_LSB +: PRIO_W];
        end
        if (wr_vec) c_d.vec[off] = bus_wdata[VEC_W-1:0];
        if (wr_spu) c_d.spu = bus_wdata[VEC_W-1:0];
        if (rd_vec) c_d.spur = ~irq_act;
        if (wr_eoi) c_d.spur = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // read mux
    logic [DATA_W-1:0] rd_mux, mode_rd;

    always_comb begin
        mode_rd = '0;
        mode_rd[1:0] = c_q.trig[off];
        mode_rd[MODE_PRIO_LSB +: PRIO_W] = c_q.prio[off];
        rd_mux = '0;
        if (rgn == RGN_W'(RGN_MODE)) begin
            rd_mux = mode_rd;
        end else if (rgn == RGN_W'(RGN_VEC)) begin
            rd_mux = DATA_W'(c_q.vec[off]);
        end else if (in_ctl) begin
            case (off)
                ID_W'(REG_VEC):  rd_mux = DATA_W'(irq_act ? c_q.vec[arb_id] : c_q.spu);
                ID_W'(REG_STAT): rd_mux = (nest_empty || c_q.spur) ? '0 : DATA_W'(top_id);
                ID_W'(REG_SPU):  rd_mux = DATA_W'(c_q.spu);
                ID_W'(REG_ENRD): rd_mux = DATA_W'(en_q);
                ID_W'(REG_PEND): rd_mux = DATA_W'(pend_eff);
                default:         rd_mux = '0;
            endcase
        end
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 7
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   bus_wr,
    input logic                                   bus_rd,
    input logic [ADDR_W-1:0]                      bus_addr,
    input logic                                   irq_n,
    input logic [N_SRC-1:0]                       en_q,
    input logic [N_SRC-1:0]                       pend_q,
    input logic [$clog2((1 << PRIO_W) + 1)-1:0]   level
);
    localparam int ID_W  = $clog2(N_SRC);
    localparam int RGN_W = ADDR_W - ID_W;
    localparam int DEPTH = 1 << PRIO_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic ctl, vec_rd, eoi_wr;
    assign ctl    = (bus_addr[ADDR_W-1:ID_W] == RGN_W'(RGN_CTL));
    assign vec_rd = bus_rd && ctl && (bus_addr[ID_W-1:0] == ID_W'(REG_VEC));
    assign eoi_wr = bus_wr && ctl && (bus_addr[ID_W-1:0] == ID_W'(REG_EOI));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> irq_n);

    p_irq_has_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|(en_q & pend_q)));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    p_ack_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !eoi_wr && !irq_n) |=> (level == CNT_W'($past(level) + 1'b1)));

    p_spur_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !eoi_wr && irq_n) |=> (level == $past(level)));

    p_eoi_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !vec_rd && level != '0) |=> (level == CNT_W'($past(level) - 1'b1)));

    p_eoi_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !vec_rd && level == '0) |=> (level == '0));
endmodule

bind prio_intc prio_intc_chk #(
    .N_SRC  (N_SRC),
    .PRIO_W (PRIO_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .irq_n    (irq_n),
    .en_q     (en_q),
    .pend_q   (pend_eff),
    .level    (nest_level)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic [31:0] src_ext = 32'h0000_0400;
    logic        irq_n;

    localparam logic [6:0] A_VEC = 7'h40, A_STAT = 7'h41, A_EOI = 7'h42, A_SPU = 7'h43;
    localparam logic [6:0] A_ENS = 7'h44, A_ENC = 7'h45, A_PCLR = 7'h46, A_EN = 7'h47, A_PEND = 7'h48;

    always #10 clk = ~clk;

    prio_intc dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .src_ext(src_ext), .irq_n(irq_n)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference model
    int          m_trig[32];
    int          m_prio[32];
    logic [31:0] m_vec[32];
    logic [31:0] m_en = '0, m_ep = '0, m_sq = '0, m_spu = '0;
    bit          m_spur = 1'b0;
    int          stk_id[$];
    int          stk_pr[$];

    function automatic bit inv_of(int i);
        return (m_trig[i] >= 2) && (i == 0 || src_ext[i]);
    endfunction

    function automatic bit pend_of(int i);
        if (m_trig[i] % 2 == 1) return m_ep[i];
        return m_sq[i] ^ inv_of(i);
    endfunction

    function automatic int winner();
        int best = -1;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && pend_of(i) && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        return best;
    endfunction

    function automatic bit active();
        int w = winner();
        if (w < 0) return 1'b0;
        if (stk_id.size() == 0) return 1'b1;
        return m_prio[w] > stk_pr[$];
    endfunction

    function automatic logic [31:0] model_read(logic [6:0] a);
        int rg = int'(a[6:5]);
        int o  = int'(a[4:0]);
        logic [31:0] p = '0;
        if (rg == 0) return 32'((m_prio[o] << 4) | m_trig[o]);
        if (rg == 1) return m_vec[o];
        if (rg == 2) begin
            case (o)
                0: return active() ? m_vec[winner()] : m_spu;
                1: return (stk_id.size() == 0 || m_spur) ? 32'd0 : 32'(stk_id[$]);
                3: return m_spu;
                7: return m_en;
                8: begin
                    for (int i = 0; i < 32; i++) p[i] = pend_of(i);
                    return p;
                end
                default: return 32'd0;
            endcase
        end
        return 32'd0;
    endfunction

    task automatic model_step(bit wr, bit rd, logic [6:0] a, logic [31:0] d);
        int rg = int'(a[6:5]);
        int o  = int'(a[4:0]);
        int w  = winner();
        bit act = active();
        logic [31:0] ack = '0, clr = '0, hit = '0;
        if (rd && rg == 2 && o == 0) begin
            if (act) begin
                stk_id.push_back(w);
                stk_pr.push_back(m_prio[w]);
                ack[w] = 1'b1;
                m_spur = 1'b0;
            end else begin
                m_spur = 1'b1;
            end
        end
        for (int i = 0; i < 32; i++) begin
            bit inv = inv_of(i);
            if (m_trig[i] % 2 == 1 && (src_in[i] ^ inv) && !(m_sq[i] ^ inv)) hit[i] = 1'b1;
        end
        if (wr && rg == 2 && o == 6) clr = d;
        m_ep = (m_ep & ~clr & ~ack) | hit;
        m_sq = src_in;
        if (wr) begin
            if (rg == 0) begin
                m_trig[o] = int'(d[1:0]);
                m_prio[o] = int'(d[6:4]);
            end else if (rg == 1) begin
                m_vec[o] = d;
            end else if (rg == 2) begin
                case (o)
                    2: begin
                        if (stk_id.size() > 0) begin
                            void'(stk_id.pop_back());
                            void'(stk_pr.pop_back());
                        end
                        m_spur = 1'b0;
                    end
                    3: m_spu = d;
                    4: m_en = m_en | d;
                    5: m_en = m_en & ~d;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle, entered and left just after a falling edge
    task automatic cycle(bit wr, bit rd, logic [6:0] a, logic [31:0] d, string tag);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #2;
        check("R6 irq_n", 32'(irq_n), 32'(!active()));
        if (rd) check(tag, bus_rdata, model_read(a));
        model_step(wr, rd, a, d);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d, string tag);
        cycle(1'b1, 1'b0, a, d, tag);
    endtask
    task automatic rd(logic [6:0] a, string tag);
        cycle(1'b0, 1'b1, a, 32'd0, tag);
    endtask
    task automatic idle();
        cycle(1'b0, 1'b0, 7'h00, 32'd0, "R6");
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_trig[i] = 0; m_prio[i] = 0; m_vec[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_n after reset", 32'(irq_n), 32'd1);
        rd(A_EN, "R1 enable mask");
        rd(A_PEND, "R1 pending");
        rd(A_STAT, "R1 status");
        rd(A_SPU, "R1 spurious vector");
        rd(A_VEC, "R1 idle vector read");

        // R3 programming and read-back
        for (int i = 0; i < 32; i++) wr(7'h20 + 7'(i), 32'hA000_0000 + 32'(i), "R3");
        for (int i = 0; i < 32; i++) wr(7'(i), 32'((i % 8) << 4), "R3");
        rd(7'h25, "R3 vector readback");
        rd(7'h05, "R3 mode readback");
        wr(7'h13, 32'hFFFF_FF37, "R3");
        rd(7'h13, "R3 unused mode bits read 0");

        // R2 write-one commands
        wr(A_ENS, 32'h0000_00FF, "R2");
        rd(A_EN, "R2 enable set");
        wr(A_ENC, 32'h0000_000F, "R2");
        rd(A_EN, "R2 enable clear");
        wr(A_ENS, 32'h0, "R2");
        wr(A_ENC, 32'h0, "R2");
        rd(A_EN, "R2 zero bits ignored");
        wr(A_ENC, 32'hFFFF_FFFF, "R2");

        // R8 R9 R10 level source
        wr(A_ENS, 32'h0000_0020, "R2");
        src_in[5] = 1'b1;
        idle();
        rd(A_PEND, "R5 level pending");
        rd(A_VEC, "R8 acknowledge");
        rd(A_STAT, "R9 status in service");
        idle();
        wr(A_EOI, 32'h1234_5678, "R10");
        rd(A_STAT, "R10 status after eoi");
        rd(A_VEC, "R8 second acknowledge");
        wr(A_EOI, 32'h0, "R10");
        src_in[5] = 1'b0;
        idle();
        wr(A_ENC, 32'hFFFF_FFFF, "R2");

        // R7 tie breaking
        wr(7'h03, 32'h40, "R3");
        wr(7'h09, 32'h40, "R3");
        wr(A_ENS, 32'h0000_0208, "R2");
        src_in[3] = 1'b1; src_in[9] = 1'b1;
        idle();
        rd(A_VEC, "R7 tie lower number");
        rd(A_STAT, "R7 tie status");
        wr(A_EOI, 32'h0, "R10");
        src_in[3] = 1'b0;
        idle();
        rd(A_VEC, "R7 remaining source");
        wr(A_EOI, 32'h0, "R10");
        src_in[9] = 1'b0;
        idle();
        wr(A_ENC, 32'hFFFF_FFFF, "R2");

        // R6 nesting by priority
        wr(A_ENS, 32'h0000_0046, "R2");
        src_in[2] = 1'b1;
        idle();
        rd(A_VEC, "R8 outer");
        src_in[6] = 1'b1;
        idle();
        rd(A_VEC, "R6 nested higher");
        rd(A_STAT, "R9 nested status");
        src_in[1] = 1'b1;
        idle();
        rd(A_VEC, "R6 lower cannot nest");
        wr(A_EOI, 32'h0, "R10");
        rd(A_STAT, "R9 status after spurious and eoi");
        wr(A_EOI, 32'h0, "R10");
        wr(A_EOI, 32'h0, "R10");
        src_in[1] = 1'b0; src_in[2] = 1'b0; src_in[6] = 1'b0;
        idle();
        wr(A_ENC, 32'hFFFF_FFFF, "R2");

        // R5 edge latch and clear
        wr(7'h0C, 32'h31, "R3");
        wr(A_ENS, 32'h0000_1000, "R2");
        src_in[12] = 1'b1;
        idle();
        src_in[12] = 1'b0;
        rd(A_PEND, "R5 edge latched");
        wr(A_PCLR, 32'h0000_1000, "R5");
        rd(A_PEND, "R5 cleared by command");
        src_in[12] = 1'b1;
        idle();
        rd(A_VEC, "R5 edge acknowledge");
        rd(A_PEND, "R5 cleared by acknowledge");
        wr(A_EOI, 32'h0, "R10");
        src_in[12] = 1'b0;
        idle();

        // R4 polarity permission
        wr(7'h07, 32'h43, "R4");
        wr(7'h0A, 32'h43, "R4");
        wr(7'h00, 32'h12, "R4");
        wr(7'h08, 32'h12, "R4");
        src_in[10] = 1'b1;
        idle();
        rd(A_PEND, "R4 low level on source 0");
        src_in[7] = 1'b1;
        idle();
        rd(A_PEND, "R4 non-external falling acts rising");
        src_in[10] = 1'b0;
        idle();
        rd(A_PEND, "R4 external falling");
        src_in[8] = 1'b1;
        idle();
        rd(A_PEND, "R4 non-external low acts high");
        wr(A_PCLR, 32'hFFFF_FFFF, "R5");
        src_in = '0;
        idle();
        rd(A_PEND, "R4 after clear");

        // R8 R9 spurious vector
        wr(A_SPU, 32'hDEAD_BEEF, "R8");
        rd(A_SPU, "R8 spurious readback");
        rd(A_VEC, "R8 spurious vector");
        rd(A_STAT, "R9 status after spurious");

        // R10 R11 eight nested levels
        for (int i = 0; i < 8; i++) wr(7'(16 + i), 32'(i << 4), "R3");
        wr(A_ENS, 32'h00FF_0000, "R2");
        for (int i = 0; i < 8; i++) begin
            src_in[16 + i] = 1'b1;
            idle();
            rd(A_VEC, "R11 nested push");
        end
        rd(A_STAT, "R11 deepest status");
        rd(A_VEC, "R11 full stack read");
        for (int i = 0; i < 8; i++) wr(A_EOI, 32'(i), "R10");
        rd(A_STAT, "R10 idle after eight eoi");
        wr(A_EOI, 32'h0, "R10");
        rd(A_STAT, "R10 eoi on empty");
        src_in = '0;
        idle();
        wr(A_ENC, 32'hFFFF_FFFF, "R2");

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            int op = $urandom_range(0, 9);
            if ($urandom_range(0, 2) == 0) begin
                int s = $urandom_range(0, 31);
                src_in[s] = ~src_in[s];
            end
            case (op)
                0, 1: rd(A_VEC, "R7 R8 mixed vector");
                2: wr(A_EOI, $urandom(), "R10");
                3: wr(A_ENS, $urandom(), "R2");
                4: wr(A_ENC, $urandom(), "R2");
                5: wr(A_PCLR, $urandom(), "R5");
                6: wr(7'($urandom_range(0, 31)),
                      32'(($urandom_range(0, 7) << 4) | $urandom_range(0, 3)), "R4");
                7: rd(A_PEND, "R5 mixed pending");
                8: rd(A_STAT, "R9 mixed status");
                default: idle();
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule